// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block sits between a host register bus and the peripheral side of an enhanced parallel port. A host access at the address offset produces one address cycle. A host access at the data offset produces one, two or four data byte cycles. Before any cycle starts, the block compares the live control register value against the single idle pattern that the cycle's direction requires. When the pattern does not match, the access completes at once and nothing is driven towards the peripheral.

Each byte cycle raises a strobe and waits for the peripheral's acknowledge. A wide access is split into byte cycles, lowest byte first, with one idle cycle between bytes. When no acknowledge arrives in time, the remaining bytes are dropped and a sticky timeout flag is raised. The host clears that flag by writing the status offset with bit 0 set.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset, busy_o, done_o, epp_stb_o and timeout_o are 0 and rdata_o is 0.
- R2: A write at offset 3 or 4 starts a strobe only when (ctrl_i & 8'h2F) == 8'h04. Any other value skips the access.
- R3: A read at offset 3 or 4 starts a strobe only when (ctrl_i & 8'h2F) == 8'h24. Any other value skips the access.
- R4: A skipped access drives no strobe and leaves timeout_o unchanged. It pulses done_o in the cycle after acceptance. A skipped read returns all ones across its byte width in rdata_o, with the upper bits zero.
- R5: Offset 3 gives exactly one byte cycle with epp_addr_o = 1, whatever size_i is. Offset 4 gives data cycles with epp_addr_o = 0 and a byte count set by size_i: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 gives 4 bytes.
- R6: Byte cycles run lowest byte first. Write byte k appears on epp_dout_o during strobe k. The byte read in cycle k lands in rdata_o bits [8k+7:8k], and the unused upper bytes read as 0.
- R7: The strobe rises in the cycle after acceptance and stays high until an acknowledge is sampled. Between two bytes of one access the strobe is low for exactly one cycle.
- R8: When no acknowledge is sampled in TIMEOUT_CYCLES strobe cycles, the strobe drops and the remaining bytes are abandoned. timeout_o is then set and done_o pulses. A failed read returns all ones across its byte width.
- R9: timeout_o is sticky. A write at offset 1 with wdata_i[0] = 1 clears it, and a write there with wdata_i[0] = 0 leaves it. A read at offset 1 returns timeout_o in bit 0 and 0 in all other bits.
- R10: busy_o is high from the cycle after an accepted cycle access until the access completes. A request made while busy_o is high is ignored.
- R11: done_o pulses for one cycle per completed access. rdata_o is then valid and holds until the next completion. For writes and for other offsets, rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host access request, taken when busy_o is low |
| we_i | input | 1 | 1 = write, 0 = read |
| off_i | input | ADDR_W | Register offset (1 status, 3 address, 4 data) |
| size_i | input | 2 | Data access width code |
| wdata_i | input | DATA_W | Host write data |
| ctrl_i | input | 8 | Current control register value |
| busy_o | output | 1 | A peripheral access is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read result, valid with done_o |
| timeout_o | output | 1 | Sticky timeout flag (status bit 0) |
| epp_stb_o | output | 1 | Peripheral strobe |
| epp_addr_o | output | 1 | 1 = address cycle, 0 = data cycle |
| epp_write_o | output | 1 | 1 = write cycle |
| epp_dout_o | output | 8 | Byte driven towards the peripheral |
| epp_din_i | input | 8 | Byte from the peripheral |
| epp_ack_i | input | 1 | Peripheral acknowledge |

## Verification
Most internal faults show up at the ports within one clock. A wrong gate decision raises or withholds the strobe in the cycle after the request. A byte index that is off by one puts the wrong lane on epp_dout_o during that strobe. A timer with the wrong length moves the falling strobe edge and the rise of timeout_o. Lane-packing faults and wrong all-ones masks stay hidden until the done_o pulse, so every completion also compares rdata_o against a model that assembles the bytes itself.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam logic [2:0] OFF_STATUS = 3'd1;
  localparam logic [2:0] OFF_ADDR   = 3'd3;
  localparam logic [2:0] OFF_DATA   = 3'd4;

  // control bits: dir=5, select=3, init=2, autolf=1, strobe=0
  localparam logic [7:0] CTRL_MASK  = 8'h2F;
  localparam logic [7:0] CTRL_IDLE_WR = 8'h04;
  localparam logic [7:0] CTRL_IDLE_RD = 8'h24;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_STB  = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/epp_mode_gate.sv
module epp_mode_gate
  import epp_gate_pkg::*;
(
  input  logic [7:0] ctrl_i,
  input  logic       we_i,
  output logic       allow_o
);
  logic [7:0] masked;

  always_comb begin
    masked  = ctrl_i & CTRL_MASK;
    allow_o = we_i ? (masked == CTRL_IDLE_WR) : (masked == CTRL_IDLE_RD);
  end
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq
  import epp_gate_pkg::*;
#(
  parameter int IDX_W          = 2,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] last_idx_i,
  input  logic             ack_i,
  output logic             busy_o,
  output logic             stb_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             take_o,
  output logic             fin_ok_o,
  output logic             fin_fail_o
);
  localparam int TMR_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [TMR_W-1:0] tmr_q;
  logic             expired;

  always_comb begin
    busy_o     = (state_q != SEQ_IDLE);
    stb_o      = (state_q == SEQ_STB);
    idx_o      = idx_q;
    expired    = (tmr_q == TMR_LAST);
    take_o     = stb_o & ack_i;
    fin_ok_o   = take_o & (idx_q == last_idx_i);
    fin_fail_o = stb_o & ~ack_i & expired;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      tmr_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_STB;
            idx_q   <= '0;
            tmr_q   <= '0;
          end
        end
        SEQ_STB: begin
          if (ack_i) begin
            state_q <= (idx_q == last_idx_i) ? SEQ_IDLE : SEQ_GAP;
          end else if (expired) begin
            state_q <= SEQ_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        SEQ_GAP: begin
          idx_q   <= idx_q + 1'b1;
          tmr_q   <= '0;
          state_q <= SEQ_STB;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_lane_pack.sv
module epp_lane_pack #(
  parameter int NB_MAX = 4,
  parameter int IDX_W  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                take_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [7:0]          byte_i,
  output logic [8*NB_MAX-1:0] merged_o
);
  for (genvar g = 0; g < NB_MAX; g++) begin : g_lane
    logic [7:0] lane_q;
    logic       hit;

    assign hit = take_i & (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lane_q <= '0;
      else if (clear_i) lane_q <= '0;
      else if (hit)     lane_q <= byte_i;
    end

    // last byte bypasses the register so completion sees it in the same edge
    assign merged_o[8*g +: 8] = hit ? byte_i : lane_q;
  end
endmodule

// File: rtl/epp_timeout_flag.sv
module epp_timeout_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_gate_pkg::*;
#(
  parameter int ADDR_W         = 3,
  parameter int DATA_W         = 32,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [7:0]        ctrl_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              timeout_o,
  output logic              epp_stb_o,
  output logic              epp_addr_o,
  output logic              epp_write_o,
  output logic [7:0]        epp_dout_o,
  input  logic [7:0]        epp_din_i,
  input  logic              epp_ack_i
);
  localparam int NB_MAX = DATA_W / 8;
  localparam int IDX_W  = (NB_MAX > 1) ? $clog2(NB_MAX) : 1;

  function automatic logic [IDX_W-1:0] size_last(input logic [1:0] sz);
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    if (n > NB_MAX) n = NB_MAX;
    return IDX_W'(n - 1);
  endfunction

  function automatic logic [DATA_W-1:0] lane_ones(input logic [IDX_W-1:0] last);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < NB_MAX; b++) begin
      if (b <= int'(last)) m[8*b +: 8] = 8'hFF;
    end
    return m;
  endfunction

  logic              accept, is_addr, is_data, is_cyc, is_status, allow, start;
  logic [IDX_W-1:0]  req_last;
  logic              op_we_q, op_addr_q;
  logic [IDX_W-1:0]  op_last_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [IDX_W-1:0]  idx;
  logic              take, fin_ok, fin_fail, seq_busy, seq_stb;
  logic [DATA_W-1:0] merged;
  logic              tmo_clr;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    is_addr   = (off_i == ADDR_W'(OFF_ADDR));
    is_data   = (off_i == ADDR_W'(OFF_DATA));
    is_status = (off_i == ADDR_W'(OFF_STATUS));
    is_cyc    = is_addr | is_data;
    accept    = req_i & ~seq_busy;
    start     = accept & is_cyc & allow;
    req_last  = is_addr ? '0 : size_last(size_i);
    tmo_clr   = accept & is_status & we_i & wdata_i[0];
  end

  epp_mode_gate u_gate (
    .ctrl_i  (ctrl_i),
    .we_i    (we_i),
    .allow_o (allow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_we_q    <= 1'b0;
      op_addr_q  <= 1'b0;
      op_last_q  <= '0;
      op_wdata_q <= '0;
    end else if (start) begin
      op_we_q    <= we_i;
      op_addr_q  <= is_addr;
      op_last_q  <= req_last;
      op_wdata_q <= wdata_i;
    end
  end

  epp_byte_seq #(
    .IDX_W          (IDX_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .last_idx_i (op_last_q),
    .ack_i      (epp_ack_i),
    .busy_o     (seq_busy),
    .stb_o      (seq_stb),
    .idx_o      (idx),
    .take_o     (take),
    .fin_ok_o   (fin_ok),
    .fin_fail_o (fin_fail)
  );

  epp_lane_pack #(
    .NB_MAX (NB_MAX),
    .IDX_W  (IDX_W)
  ) u_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start),
    .take_i   (take & ~op_we_q),
    .idx_i    (idx),
    .byte_i   (epp_din_i),
    .merged_o (merged)
  );

  epp_timeout_flag u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fin_fail),
    .clr_i  (tmo_clr),
    .flag_o (timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept && !is_cyc) begin
        done_q  <= 1'b1;
        rdata_q <= (is_status && !we_i) ? {{(DATA_W-1){1'b0}}, timeout_o} : '0;
      end else if (accept && is_cyc && !allow) begin
        done_q  <= 1'b1;
        rdata_q <= we_i ? '0 : lane_ones(req_last);
      end else if (fin_ok) begin
        done_q  <= 1'b1;
        rdata_q <= op_we_q ? '0 : merged;
      end else if (fin_fail) begin
        done_q  <= 1'b1;
        rdata_q <= op_we_q ? '0 : lane_ones(op_last_q);
      end
    end
  end

  always_comb begin
    busy_o      = seq_busy;
    done_o      = done_q;
    rdata_o     = rdata_q;
    epp_stb_o   = seq_stb;
    epp_addr_o  = op_addr_q;
    epp_write_o = op_we_q;
    epp_dout_o  = op_wdata_q[8*idx +: 8];
  end
endmodule

// File: rtl/epp_cycle_gate_chk.sv
module epp_cycle_gate_chk
  import epp_gate_pkg::*;
#(
  parameter int ADDR_W         = 3,
  parameter int DATA_W         = 32,
  parameter int TIMEOUT_CYCLES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] off_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [7:0]        ctrl_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              timeout_o,
  input logic              epp_stb_o,
  input logic              epp_addr_o,
  input logic              epp_write_o,
  input logic [7:0]        epp_dout_o,
  input logic [7:0]        epp_din_i,
  input logic              epp_ack_i
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 2);

  logic             take_new, cyc_off, clr_req;
  logic [CNT_W-1:0] stb_run_q;

  assign take_new = req_i & ~busy_o;
  assign cyc_off  = (off_i == ADDR_W'(OFF_ADDR)) | (off_i == ADDR_W'(OFF_DATA));
  assign clr_req  = take_new & (off_i == ADDR_W'(OFF_STATUS)) & we_i & wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stb_run_q <= '0;
    else if (epp_stb_o) stb_run_q <= stb_run_q + 1'b1;
    else                stb_run_q <= '0;
  end

  p_wr_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_new && we_i && cyc_off && ((ctrl_i & CTRL_MASK) != CTRL_IDLE_WR))
      |=> (!epp_stb_o && done_o));

  p_rd_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_new && !we_i && cyc_off && ((ctrl_i & CTRL_MASK) != CTRL_IDLE_RD))
      |=> (!epp_stb_o && done_o));

  p_stb_in_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epp_stb_o |-> busy_o);

  p_dout_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epp_stb_o && $past(epp_stb_o)) |-> ($stable(epp_dout_o) && $stable(epp_addr_o)
                                          && $stable(epp_write_o)));

  p_stb_bounded_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epp_stb_o |-> (stb_run_q < CNT_W'(TIMEOUT_CYCLES)));

  p_tmo_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($past(epp_stb_o) && done_o));

  p_tmo_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !clr_req) |=> timeout_o);

  p_busy_end_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !epp_stb_o);

  // reads keep rdata only on completion
  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o) || $past(done_o) == 1'b0);

  logic unused_ok;
  assign unused_ok = ^{size_i, epp_din_i, epp_ack_i, wdata_i[DATA_W-1:1]};
endmodule

bind epp_cycle_gate epp_cycle_gate_chk #(
  .ADDR_W         (ADDR_W),
  .DATA_W         (DATA_W),
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .off_i       (off_i),
  .size_i      (size_i),
  .wdata_i     (wdata_i),
  .ctrl_i      (ctrl_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .timeout_o   (timeout_o),
  .epp_stb_o   (epp_stb_o),
  .epp_addr_o  (epp_addr_o),
  .epp_write_o (epp_write_o),
  .epp_dout_o  (epp_dout_o),
  .epp_din_i   (epp_din_i),
  .epp_ack_i   (epp_ack_i)
);

// File: tb/epp_cycle_gate_tb_top.sv
`timescale 1ns/1ps
module epp_cycle_gate_tb_top;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  off = '0;
  logic [1:0]  size = '0;
  logic [31:0] wd = '0;
  logic [7:0]  ctrl = 8'h0C;
  logic        busy, done, tmo, stb, addr_c, wr_c;
  logic [31:0] rdata;
  logic [7:0]  dout;
  logic [7:0]  din = '0;
  logic        ack = 1'b0;

  int errs = 0, checks = 0;
  bit finished = 0;
  string cur_req = "R1";
  int ack_delay = 0;
  int ack_bytes = 4;
  logic [7:0] din_base = 8'h10;

  // reference model state
  int          m_st = 0, m_idx = 0, m_cnt = 0, m_nb = 1;
  bit          m_we = 0, m_addr = 0, m_done = 0, m_tmo = 0;
  logic [31:0] m_wd = '0, m_acc = '0, m_rdata = '0;

  always #2.5 clk = ~clk;

  epp_cycle_gate #(.ADDR_W(3), .DATA_W(32), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .off_i(off),
    .size_i(size), .wdata_i(wd), .ctrl_i(ctrl), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .timeout_o(tmo), .epp_stb_o(stb), .epp_addr_o(addr_c),
    .epp_write_o(wr_c), .epp_dout_o(dout), .epp_din_i(din), .epp_ack_i(ack)
  );

  function automatic logic [31:0] ones_w(input int nb);
    logic [31:0] m = '0;
    for (int b = 0; b < nb; b++) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_cnt = 0; m_done = 0; m_tmo = 0; m_rdata = '0;
      m_acc = '0; m_we = 0; m_addr = 0; m_wd = '0; m_nb = 1;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (req) begin
          if (off == 3'd1) begin
            m_done = 1;
            m_rdata = we ? 32'h0 : {31'h0, m_tmo};
            if (we && wd[0]) m_tmo = 0;
          end else if (off == 3'd3 || off == 3'd4) begin
            int nb;
            bit ok;
            nb = (off == 3'd3) ? 1 : (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
            ok = we ? ((ctrl & 8'h2F) == 8'h04) : ((ctrl & 8'h2F) == 8'h24);
            if (!ok) begin
              m_done = 1;
              m_rdata = we ? 32'h0 : ones_w(nb);
            end else begin
              m_st = 1; m_idx = 0; m_cnt = 0; m_acc = '0; m_nb = nb;
              m_we = we; m_addr = (off == 3'd3); m_wd = wd;
            end
          end else begin
            m_done = 1;
            m_rdata = '0;
          end
        end
        1: begin
          if (ack) begin
            m_acc[8*m_idx +: 8] = din;
            if (m_idx == m_nb - 1) begin
              m_st = 0; m_done = 1; m_rdata = m_we ? 32'h0 : m_acc;
            end else m_st = 2;
          end else if (m_cnt == TMO - 1) begin
            m_st = 0; m_done = 1; m_tmo = 1;
            m_rdata = m_we ? 32'h0 : ones_w(m_nb);
          end else m_cnt++;
        end
        default: begin
          m_idx++; m_cnt = 0; m_st = 1;
        end
      endcase
    end
  end

  // peripheral responder, driven from the model's view of the strobe
  always @(negedge clk) begin
    ack = (m_st == 1) && (m_cnt == ack_delay) && (m_idx < ack_bytes);
    din = din_base + 8'(m_idx * 17);
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(cur_req, "busy", {31'h0, busy}, {31'h0, m_st != 0});
      chk(cur_req, "stb", {31'h0, stb}, {31'h0, m_st == 1});
      chk(cur_req, "done", {31'h0, done}, {31'h0, m_done});
      chk(cur_req, "rdata", rdata, m_rdata);
      chk(cur_req, "timeout", {31'h0, tmo}, {31'h0, m_tmo});
      if (m_st == 1) begin
        chk(cur_req, "addr_cyc", {31'h0, addr_c}, {31'h0, m_addr});
        chk(cur_req, "write", {31'h0, wr_c}, {31'h0, m_we});
        if (m_we) chk(cur_req, "dout", {24'h0, dout}, {24'h0, m_wd[8*m_idx +: 8]});
      end
    end
  end

  task automatic access(input bit w, input logic [2:0] o, input logic [1:0] s,
                        input logic [31:0] d, input logic [7:0] c);
    @(negedge clk);
    req = 1; we = w; off = o; size = s; wd = d; ctrl = c;
    @(negedge clk);
    req = 0;
    while (m_st != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", "reset busy", {31'h0, busy}, 32'h0);
    chk("R1", "reset stb", {31'h0, stb}, 32'h0);
    chk("R1", "reset timeout", {31'h0, tmo}, 32'h0);
    chk("R1", "reset rdata", rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R2"; ack_delay = 2; ack_bytes = 4;
    access(1, 3'd4, 2'd0, 32'h0000_00A5, 8'h04);
    access(1, 3'd4, 2'd0, 32'h0000_003C, 8'hC4);   // bits outside mask ignored
    access(1, 3'd4, 2'd0, 32'h0000_0011, 8'h0C);   // select set: skipped
    access(1, 3'd4, 2'd0, 32'h0000_0011, 8'h24);   // dir set on write: skipped

    cur_req = "R3"; din_base = 8'h10; ack_delay = 1;
    access(0, 3'd4, 2'd2, 32'h0, 8'h24);
    chk("R3", "4-byte read", rdata, 32'h4332_2110);
    access(0, 3'd4, 2'd0, 32'h0, 8'h25);           // strobe bit set: skipped

    cur_req = "R4";
    access(0, 3'd4, 2'd2, 32'h0, 8'h04);
    chk("R4", "skipped 4-byte read", rdata, 32'hFFFF_FFFF);
    access(0, 3'd4, 2'd1, 32'h0, 8'h2C);
    chk("R4", "skipped 2-byte read", rdata, 32'h0000_FFFF);

    cur_req = "R5"; ack_delay = 0;
    access(1, 3'd3, 2'd2, 32'h1234_5677, 8'h04);
    access(0, 3'd3, 2'd2, 32'h0, 8'h24);
    chk("R5", "address read one byte", rdata, {24'h0, din_base});

    cur_req = "R6"; ack_delay = 3;
    access(1, 3'd4, 2'd1, 32'h0000_BEEF, 8'h04);
    access(1, 3'd4, 2'd3, 32'hCAFE_F00D, 8'h04);
    din_base = 8'h80;
    access(0, 3'd4, 2'd1, 32'h0, 8'h24);
    chk("R6", "2-byte read lanes", rdata, 32'h0000_9180);

    cur_req = "R7"; ack_delay = 5;
    access(0, 3'd4, 2'd2, 32'h0, 8'hE4);

    cur_req = "R8"; ack_delay = 1; ack_bytes = 1;
    access(0, 3'd4, 2'd2, 32'h0, 8'h24);
    chk("R8", "failed read mask", rdata, 32'hFFFF_FFFF);
    chk("R8", "flag after fail", {31'h0, tmo}, 32'h1);
    ack_bytes = 0;
    access(1, 3'd4, 2'd1, 32'h0000_5555, 8'h04);

    cur_req = "R10"; ack_bytes = 4; ack_delay = 3;
    @(negedge clk);
    req = 1; we = 0; off = 3'd4; size = 2'd2; ctrl = 8'h24;
    @(negedge clk);
    we = 1; off = 3'd1; wd = 32'h1;                  // clear attempt while busy
    @(negedge clk);
    @(negedge clk);
    req = 0;
    while (m_st != 0) @(negedge clk);
    chk("R10", "clear ignored while busy", {31'h0, tmo}, 32'h1);

    cur_req = "R9";
    access(1, 3'd1, 2'd0, 32'h0000_00FE, 8'h00);
    chk("R9", "bit0 clear leaves flag", {31'h0, tmo}, 32'h1);
    access(0, 3'd1, 2'd0, 32'h0, 8'h00);
    chk("R9", "status read", rdata, 32'h1);
    access(1, 3'd1, 2'd0, 32'h0000_0001, 8'h00);
    chk("R9", "flag cleared", {31'h0, tmo}, 32'h0);
    access(0, 3'd1, 2'd0, 32'h0, 8'h00);
    chk("R9", "status read after clear", rdata, 32'h0);

    cur_req = "R11";
    access(1, 3'd5, 2'd0, 32'hFFFF_FFFF, 8'h04);
    chk("R11", "other offset rdata", rdata, 32'h0);
    access(1, 3'd4, 2'd2, 32'h0102_0304, 8'h04);
    chk("R11", "write rdata", rdata, 32'h0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule